// File: doc/BRIEF.md
# System Power State Sequencer

This block is a synchronous state machine that holds the current platform power state and chooses the next one on every clock. It covers five processor states inside the working state (C0 to C4), three sleep states (S1, S3, S4), soft-off (S5) and mechanical-off (G3). Each cycle it looks at a set of single-cycle event pulses, a few configuration bits, a requested sleep type and a battery-low level. It then moves to the next state or stays where it is.

The state is published as a 4-bit code and as a one-hot flag vector. The processor-state moves depend on configuration. One bit picks the deep state reached by a level-3 read. Another makes a level-3 read stop in C2 until the bus masters go idle. A third picks C3 or C4 when C2 is promoted again. A fourth makes a bus-master event drop only to C2 instead of C0. While battery-low is asserted, a request to return to C0 from sleep, soft-off or mechanical-off is remembered, and the return happens once battery-low clears.

Top module: `pwrseq_top`

## Requirements
- R1: A synchronous active-high reset places the machine in G3. The state codes are C0=0, C1=1, C2=2, C3=3, C4=4, S1=5, S3=6, S4=7, S5=8 and G3=9. The state changes at the clock edge that samples its trigger.
- R2: In C0, a halt pulse moves to C1, a level-2 read moves to C2 and a level-4 read moves to C4. When several C0 triggers arrive together, the order of precedence is sleep-enable, then level-4, then level-3, then level-2, then halt.
- R3: In C0, a level-3 read moves to C2 when the bus-master-zero enable is set, and marks C2 as eligible for promotion. With that enable clear, the read moves to C4 if the deep-on-level-3 bit is set and to C3 if it is not.
- R4: In C0, sleep-enable moves to the state chosen by sleep_type: 0=S1, 1=S3, 2=S4, 3=S5.
- R5: A power-failure pulse moves any state other than G3 to G3 on the next edge. It wins over every other event.
- R6: A power-button override moves any working or sleep state to S5. It loses only to power failure, wins over all other events, and has no effect in S5 or G3.
- R7: In C1, a break moves to C0, and a clock-stop pulse moves to C2. If both arrive together, the break wins.
- R8: In C2, a break moves to C0. A bus-master-idle pulse promotes the machine to C4 when the promotion bit is set and to C3 when it is clear, but only if C2 was entered from C3 or C4, or through R3. Entering C0 removes that eligibility.
- R9: In C3 or C4, a break moves to C0. A bus-master event moves to C2 (eligible for promotion) when the pop-up bit is set, and to C0 when it is clear.
- R10: In S1, S3, S4 or S5, a wake pulse moves to C0. In G3, a power-return pulse moves to C0 when the reboot bit is set and to S5 when it is clear.
- R11: While battery-low is high, a wake or reboot power-return is held and the state does not change. The move to C0 happens on the first edge at which battery-low is low. G3 to S5 is not held.
- R12: An event that has no transition defined for the current state leaves the state unchanged.
- R13: state_hot has exactly one bit set, at the index equal to state_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_halt | input | 1 | Processor halt pulse |
| ev_lvl2_rd | input | 1 | Level-2 register read pulse |
| ev_lvl3_rd | input | 1 | Level-3 register read pulse |
| ev_lvl4_rd | input | 1 | Level-4 register read pulse |
| ev_sleep_en | input | 1 | Sleep-enable write pulse |
| ev_pbtn_ovr | input | 1 | Power-button override pulse |
| ev_pwr_fail | input | 1 | Power failure pulse |
| ev_pwr_ret | input | 1 | Power return pulse |
| ev_break | input | 1 | Enabled break event pulse |
| ev_bm | input | 1 | Bus-master activity pulse |
| ev_wake | input | 1 | Enabled wake event pulse |
| ev_clk_stop | input | 1 | Clock-stop assertion pulse |
| ev_bm_idle | input | 1 | Bus masters idle pulse |
| cfg_deep_l3 | input | 1 | Level-3 read goes to C4 rather than C3 |
| cfg_bm_zero | input | 1 | Level-3 read waits in C2 for idle bus masters |
| cfg_promote_deep | input | 1 | C2 promotion goes to C4 rather than C3 |
| cfg_popup | input | 1 | Bus-master event in C3/C4 goes to C2 rather than C0 |
| cfg_reboot | input | 1 | Power return in G3 goes to C0 rather than S5 |
| sleep_type | input | 2 | Requested sleep target |
| batlow | input | 1 | Battery-low level |
| state_code | output | 4 | Current state code |
| state_hot | output | 10 | One-hot state flags |

## Verification
The hardest state to reach from the ports is a promotion from C2. The C2 state must have been entered from C3 or C4, or by a level-3 read with the bus-master-zero bit set, and no visit to C0 may have happened since. The stimulus first drives C0 to C3 with a level-3 read, then sends a bus-master event with pop-up set, then a bus-master-idle pulse. A second pass enters C2 straight from C0 and checks that the idle pulse now does nothing. Battery-low deferral is covered by raising battery-low before a wake or power-return pulse, holding it for extra cycles, and checking that C0 appears exactly one edge after it drops.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    localparam int NUM_STATES = 10;
    localparam int STATE_W    = $clog2(NUM_STATES);

    typedef enum logic [STATE_W-1:0] {
        PS_C0 = 4'd0,
        PS_C1 = 4'd1,
        PS_C2 = 4'd2,
        PS_C3 = 4'd3,
        PS_C4 = 4'd4,
        PS_S1 = 4'd5,
        PS_S3 = 4'd6,
        PS_S4 = 4'd7,
        PS_S5 = 4'd8,
        PS_G3 = 4'd9
    } pstate_e;

    typedef struct packed {
        logic halt;
        logic lvl2;
        logic lvl3;
        logic lvl4;
        logic slp_en;
        logic pbo;
        logic pwr_fail;
        logic pwr_ret;
        logic brk;
        logic bm_evt;
        logic wake;
        logic clk_stop;
        logic bm_idle;
    } evt_t;

    typedef struct packed {
        logic deep_l3;
        logic bm_zero;
        logic promote_deep;
        logic popup;
        logic reboot;
    } cfg_t;

    function automatic logic is_working(input pstate_e s);
        return (s <= PS_C4);
    endfunction

    function automatic pstate_e sleep_target(input logic [1:0] t);
        case (t)
            2'd0:    return PS_S1;
            2'd1:    return PS_S3;
            2'd2:    return PS_S4;
            default: return PS_S5;
        endcase
    endfunction

endpackage

// File: rtl/pwrseq_next.sv
module pwrseq_next
    import pwrseq_pkg::*;
(
    input  pstate_e    cur,
    input  evt_t       ev,
    input  cfg_t       cfg,
    input  logic [1:0] slp_type,
    input  logic       batlow,
    input  logic       mark_q,
    input  logic       pend_q,
    output pstate_e    nxt,
    output logic       mark_d,
    output logic       pend_d
);

    logic mark_set;

    always_comb begin
        nxt      = cur;
        mark_set = 1'b0;
        pend_d   = pend_q;

        if (ev.pwr_fail && cur != PS_G3) begin
            nxt = PS_G3;
        end else if (ev.pbo && cur <= PS_S4) begin
            nxt = PS_S5;
        end else begin
            case (cur)
                PS_C0: begin
                    if (ev.slp_en)    nxt = sleep_target(slp_type);
                    else if (ev.lvl4) nxt = PS_C4;
                    else if (ev.lvl3) begin
                        if (cfg.bm_zero) begin
                            nxt      = PS_C2;
                            mark_set = 1'b1;
                        end else begin
                            nxt = cfg.deep_l3 ? PS_C4 : PS_C3;
                        end
                    end
                    else if (ev.lvl2) nxt = PS_C2;
                    else if (ev.halt) nxt = PS_C1;
                end
                PS_C1: begin
                    if (ev.brk)           nxt = PS_C0;
                    else if (ev.clk_stop) nxt = PS_C2;
                end
                PS_C2: begin
                    if (ev.brk)                       nxt = PS_C0;
                    else if (ev.bm_idle && mark_q)    nxt = cfg.promote_deep ? PS_C4 : PS_C3;
                end
                PS_C3, PS_C4: begin
                    if (ev.brk) nxt = PS_C0;
                    else if (ev.bm_evt) begin
                        if (cfg.popup) begin
                            nxt      = PS_C2;
                            mark_set = 1'b1;
                        end else begin
                            nxt = PS_C0;
                        end
                    end
                end
                PS_S1, PS_S3, PS_S4, PS_S5: begin
                    if (ev.wake || pend_q) begin
                        if (batlow) pend_d = 1'b1;
                        else        nxt    = PS_C0;
                    end
                end
                PS_G3: begin
                    if (ev.pwr_ret || pend_q) begin
                        if (!cfg.reboot)  nxt    = PS_S5;
                        else if (batlow)  pend_d = 1'b1;
                        else              nxt    = PS_C0;
                    end
                end
                default: nxt = PS_G3;
            endcase
        end

        if (nxt != cur) pend_d = 1'b0;
    end

    always_comb begin
        if (mark_set)                              mark_d = 1'b1;
        else if (nxt == PS_C0 || !is_working(nxt)) mark_d = 1'b0;
        else                                       mark_d = mark_q;
    end

endmodule

// File: rtl/pwrseq_decode.sv
module pwrseq_decode
    import pwrseq_pkg::*;
#(
    parameter int N = NUM_STATES,
    parameter int W = STATE_W
) (
    input  logic [W-1:0] code,
    output logic [N-1:0] hot
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        assign hot[i] = (code == W'(i));
    end

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
    import pwrseq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ev_halt,
    input  logic                  ev_lvl2_rd,
    input  logic                  ev_lvl3_rd,
    input  logic                  ev_lvl4_rd,
    input  logic                  ev_sleep_en,
    input  logic                  ev_pbtn_ovr,
    input  logic                  ev_pwr_fail,
    input  logic                  ev_pwr_ret,
    input  logic                  ev_break,
    input  logic                  ev_bm,
    input  logic                  ev_wake,
    input  logic                  ev_clk_stop,
    input  logic                  ev_bm_idle,
    input  logic                  cfg_deep_l3,
    input  logic                  cfg_bm_zero,
    input  logic                  cfg_promote_deep,
    input  logic                  cfg_popup,
    input  logic                  cfg_reboot,
    input  logic [1:0]            sleep_type,
    input  logic                  batlow,
    output logic [STATE_W-1:0]    state_code,
    output logic [NUM_STATES-1:0] state_hot
);

    evt_t    ev;
    cfg_t    cfg;
    pstate_e state_q, state_d;
    logic    mark_q, mark_d;
    logic    pend_q, pend_d;

    assign ev = '{halt: ev_halt, lvl2: ev_lvl2_rd, lvl3: ev_lvl3_rd, lvl4: ev_lvl4_rd,
                  slp_en: ev_sleep_en, pbo: ev_pbtn_ovr, pwr_fail: ev_pwr_fail,
                  pwr_ret: ev_pwr_ret, brk: ev_break, bm_evt: ev_bm, wake: ev_wake,
                  clk_stop: ev_clk_stop, bm_idle: ev_bm_idle};

    assign cfg = '{deep_l3: cfg_deep_l3, bm_zero: cfg_bm_zero,
                   promote_deep: cfg_promote_deep, popup: cfg_popup, reboot: cfg_reboot};

    pwrseq_next next_i (
        .cur      (state_q),
        .ev       (ev),
        .cfg      (cfg),
        .slp_type (sleep_type),
        .batlow   (batlow),
        .mark_q   (mark_q),
        .pend_q   (pend_q),
        .nxt      (state_d),
        .mark_d   (mark_d),
        .pend_d   (pend_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_G3;
            mark_q  <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            mark_q  <= mark_d;
            pend_q  <= pend_d;
        end
    end

    assign state_code = state_q;

    pwrseq_decode #(.N(NUM_STATES), .W(STATE_W)) decode_i (
        .code (state_code),
        .hot  (state_hot)
    );

endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk
    import pwrseq_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  ev_pwr_fail,
    input logic                  ev_pbtn_ovr,
    input logic                  ev_break,
    input logic                  batlow,
    input logic [STATE_W-1:0]    state_code,
    input logic [NUM_STATES-1:0] state_hot,
    input logic                  mark_q
);

    assert_pwrfail_g3_R5: assert property (@(posedge clk) disable iff (rst)
        ev_pwr_fail |=> state_code == PS_G3);

    assert_override_s5_R6: assert property (@(posedge clk) disable iff (rst)
        (ev_pbtn_ovr && !ev_pwr_fail && state_code <= PS_S4) |=> state_code == PS_S5);

    assert_break_c0_R7: assert property (@(posedge clk) disable iff (rst)
        (ev_break && !ev_pwr_fail && !ev_pbtn_ovr && state_code >= PS_C1 && state_code <= PS_C4)
        |=> state_code == PS_C0);

    assert_batlow_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (batlow && state_code >= PS_S1) |=> state_code != PS_C0);

    assert_mark_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (state_code == PS_C0) |-> !mark_q);

    assert_onehot_R13: assert property (@(posedge clk) disable iff (rst)
        $countones(state_hot) == 1 && state_hot[state_code]);

endmodule

bind pwrseq_top pwrseq_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .ev_pwr_fail (ev_pwr_fail),
    .ev_pbtn_ovr (ev_pbtn_ovr),
    .ev_break    (ev_break),
    .batlow      (batlow),
    .state_code  (state_code),
    .state_hot   (state_hot),
    .mark_q      (mark_q)
);

// File: tb/pwrseq_top_tb_top.sv
`timescale 1ns/1ps
module pwrseq_top_tb_top;
    import pwrseq_pkg::*;

    localparam int M_HALT = 1 << 0,  M_L2 = 1 << 1,  M_L3 = 1 << 2,  M_L4 = 1 << 3;
    localparam int M_SLP  = 1 << 4,  M_PBO = 1 << 5, M_PF = 1 << 6,  M_RET = 1 << 7;
    localparam int M_BRK  = 1 << 8,  M_BM = 1 << 9,  M_WAKE = 1 << 10;
    localparam int M_CSTP = 1 << 11, M_IDLE = 1 << 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [12:0] evv = '0;
    logic cfg_deep_l3 = 0, cfg_bm_zero = 0, cfg_promote_deep = 0, cfg_popup = 0, cfg_reboot = 1;
    logic [1:0] sleep_type = 2'd0;
    logic batlow = 1'b0;
    logic [3:0] state_code;
    logic [9:0] state_hot;
    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pwrseq_top dut_i (
        .clk(clk), .rst(rst),
        .ev_halt(evv[0]), .ev_lvl2_rd(evv[1]), .ev_lvl3_rd(evv[2]), .ev_lvl4_rd(evv[3]),
        .ev_sleep_en(evv[4]), .ev_pbtn_ovr(evv[5]), .ev_pwr_fail(evv[6]), .ev_pwr_ret(evv[7]),
        .ev_break(evv[8]), .ev_bm(evv[9]), .ev_wake(evv[10]), .ev_clk_stop(evv[11]),
        .ev_bm_idle(evv[12]),
        .cfg_deep_l3(cfg_deep_l3), .cfg_bm_zero(cfg_bm_zero), .cfg_promote_deep(cfg_promote_deep),
        .cfg_popup(cfg_popup), .cfg_reboot(cfg_reboot), .sleep_type(sleep_type), .batlow(batlow),
        .state_code(state_code), .state_hot(state_hot)
    );

    task automatic chk(input string req, input logic [3:0] exp);
        checks++;
        if (state_code !== exp || state_hot !== (10'b1 << exp)) begin
            fails++;
            $display("FAIL %s: state=%0d hot=%b expected state=%0d hot=%b",
                     req, state_code, state_hot, exp, 10'b1 << exp);
        end
    endtask

    task automatic fire(input int mask);
        @(negedge clk);
        evv = mask[12:0];
        @(negedge clk);
        evv = '0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; evv = '0; batlow = 0;
        cfg_deep_l3 = 0; cfg_bm_zero = 0; cfg_promote_deep = 0; cfg_popup = 0; cfg_reboot = 1;
        sleep_type = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    task automatic reach(input int s);
        do_reset();
        if (s == PS_G3) return;
        fire(M_RET);
        case (s)
            PS_C1: fire(M_HALT);
            PS_C2: fire(M_L2);
            PS_C3: fire(M_L3);
            PS_C4: fire(M_L4);
            PS_S1: begin sleep_type = 0; fire(M_SLP); end
            PS_S3: begin sleep_type = 1; fire(M_SLP); end
            PS_S4: begin sleep_type = 2; fire(M_SLP); end
            PS_S5: begin sleep_type = 3; fire(M_SLP); end
            default: ;
        endcase
    endtask

    function automatic logic [3:0] exp_sleep(input int t);
        case (t)
            0: return PS_S1;
            1: return PS_S3;
            2: return PS_S4;
            default: return PS_S5;
        endcase
    endfunction

    initial begin
        do_reset();
        chk("R1 reset state", PS_G3);

        // R10 power return, both reboot settings, then wake from S5
        cfg_reboot = 0; fire(M_RET); chk("R10 G3 return no reboot", PS_S5);
        fire(M_WAKE); chk("R10 S5 wake", PS_C0);
        do_reset(); fire(M_RET); chk("R10 G3 return reboot", PS_C0);

        // R2 C0 triggers and precedence
        reach(PS_C0); fire(M_HALT); chk("R2 halt", PS_C1);
        reach(PS_C0); fire(M_L2); chk("R2 level2", PS_C2);
        reach(PS_C0); fire(M_L4); chk("R2 level4", PS_C4);
        reach(PS_C0); fire(M_L2 | M_HALT); chk("R2 l2 over halt", PS_C2);
        reach(PS_C0); fire(M_L3 | M_L2 | M_HALT); chk("R2 l3 over l2", PS_C3);
        reach(PS_C0); fire(M_L4 | M_L3 | M_HALT); chk("R2 l4 over l3", PS_C4);
        reach(PS_C0); sleep_type = 1; fire(M_SLP | M_L4 | M_HALT); chk("R2 sleep over l4", PS_S3);

        // R3 level-3 sweep over both config bits
        for (int d = 0; d < 2; d++) begin
            for (int z = 0; z < 2; z++) begin
                reach(PS_C0);
                cfg_deep_l3 = d[0]; cfg_bm_zero = z[0];
                fire(M_L3);
                chk("R3 level3 target", z ? PS_C2 : (d ? PS_C4 : PS_C3));
                if (z) begin
                    cfg_promote_deep = d[0];
                    fire(M_IDLE);
                    chk("R3 R8 promotion after bm-zero entry", d ? PS_C4 : PS_C3);
                end
            end
        end

        // R4 sleep type sweep with wake back (R10)
        for (int t = 0; t < 4; t++) begin
            reach(PS_C0); sleep_type = t[1:0];
            fire(M_SLP); chk("R4 sleep target", exp_sleep(t));
            fire(M_WAKE); chk("R10 wake to C0", PS_C0);
        end

        // R5 power failure from every state, against competing events
        for (int s = 0; s < 10; s++) begin
            reach(s);
            fire(M_PF | M_PBO | M_BRK | M_WAKE);
            chk("R5 power fail", PS_G3);
        end

        // R6 override from every state, reboot off
        for (int s = 0; s < 10; s++) begin
            reach(s); cfg_reboot = 0;
            fire(M_PBO | M_BRK | M_RET | M_BM | M_IDLE);
            chk("R6 override", PS_S5);
        end

        // R7 C1 exits
        reach(PS_C1); fire(M_BRK); chk("R7 C1 break", PS_C0);
        reach(PS_C1); fire(M_CSTP); chk("R7 C1 clock stop", PS_C2);
        reach(PS_C1); fire(M_BRK | M_CSTP); chk("R7 break over clock stop", PS_C0);

        // R8 promotion eligibility
        reach(PS_C2); fire(M_BRK); chk("R8 C2 break", PS_C0);
        reach(PS_C3); cfg_popup = 1; fire(M_BM); chk("R9 C3 popup", PS_C2);
        cfg_promote_deep = 1; fire(M_IDLE); chk("R8 promote to C4", PS_C4);
        fire(M_BM); chk("R9 C4 popup", PS_C2);
        cfg_promote_deep = 0; fire(M_IDLE); chk("R8 promote to C3", PS_C3);
        fire(M_BRK); chk("R9 C3 break", PS_C0);
        fire(M_L2); fire(M_IDLE); chk("R8 no promotion after C0", PS_C2);

        // R9 pop-up off
        reach(PS_C3); fire(M_BM); chk("R9 C3 bm no popup", PS_C0);
        reach(PS_C4); fire(M_BM); chk("R9 C4 bm no popup", PS_C0);
        reach(PS_C4); fire(M_BRK | M_BM); chk("R9 C4 break", PS_C0);

        // R11 battery-low deferral
        reach(PS_S3); batlow = 1; fire(M_WAKE); chk("R11 wake held", PS_S3);
        idle(); idle(); chk("R11 still held", PS_S3);
        batlow = 0; idle(); chk("R11 released", PS_C0);
        do_reset(); batlow = 1; fire(M_RET); chk("R11 reboot held", PS_G3);
        idle(); batlow = 0; idle(); chk("R11 reboot released", PS_C0);
        do_reset(); batlow = 1; cfg_reboot = 0; fire(M_RET); chk("R11 G3 to S5 not held", PS_S5);

        // R12 events without a transition
        reach(PS_C0); fire(M_BRK | M_WAKE | M_RET | M_BM | M_CSTP | M_IDLE);
        chk("R12 C0 ignores", PS_C0);
        reach(PS_C1); fire(M_HALT | M_L2 | M_WAKE | M_BM); chk("R12 C1 ignores", PS_C1);
        reach(PS_C2); fire(M_IDLE | M_HALT | M_BM); chk("R12 C2 idle without mark", PS_C2);
        reach(PS_S1); fire(M_HALT | M_BRK | M_L2 | M_RET); chk("R12 S1 ignores", PS_S1);
        do_reset(); fire(M_WAKE | M_BRK | M_PBO); chk("R12 G3 ignores", PS_G3);
        reach(PS_S5); fire(M_PBO | M_RET); chk("R12 S5 ignores override", PS_S5);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule